// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the 16-bit power management control and status word of a network controller function. A host reads and writes it through a plain register port: a select strobe, a write enable, two byte lanes and a data bus, with combinational read data. The word holds five things:

- a sticky wake-event flag that the host clears by writing 1 to it;
- a wake-signal enable;
- a four-bit data-select field, with a read-only two-bit scale field derived from it;
- a two-bit device power state;
- several bits that always read as zero.

The block drives a registered, active-low wake output from the flag and the enable. It also presents the current power state to the rest of the device.

The wake flag is a two-state machine. `WK_IDLE` means that no event is pending. `WK_PEND` means that a wake event has been latched.

- `WK_IDLE` to `WK_PEND`: a wake event arrives.
- `WK_PEND` to `WK_IDLE`: a clear write arrives without a simultaneous event.
- In every other case the machine stays in its current state.

The power state is held as an enumerated value with four states, `PWR_D0` to `PWR_D3`.

Top module: `pm_csr_top`

## Requirements
- R1: After reset, every stored field is zero and `wake_n` is high. A read then returns 4000h, because the derived scale field shows 10b for select value 0. `pwr_state` is 00 (D0).
- R2: A one-cycle `wake_evt` pulse sets bit 15 (wake status) on the next clock edge, whether bit 8 (wake enable) is 0 or 1.
- R3: A write that selects the register, has `byte_en[1]` set and has `wr_data[15]` = 1 clears bit 15. A write with `wr_data[15]` = 0 leaves bit 15 unchanged.
- R4: When a wake event and a clearing write happen in the same cycle, bit 15 stays 1.
- R5: `wake_n` is registered. It goes low one clock after bit 15 and bit 8 are both 1. It goes high one clock after either of them is 0.
- R6: Bits 12:9 (data select) and bit 8 (wake enable) are read/write through byte lane 1.
- R7: Bits 14:13 (scale) are read-only. They read 10b when the select value is 0 to 8, and 00b when it is 9 to 15.
- R8: Bits 1:0 are a read/write power state, written through byte lane 0. The encodings are 00 = D0, 01 = D1, 10 = D2 and 11 = D3. The stored value is driven on `pwr_state`.
- R9: Bits 7:2 always read 0, and writes to them are ignored. Bit 4 is 0 because dynamic power monitoring is not supported.
- R10: A write with `byte_en[1]` = 0 changes none of bits 15:8. A write with `byte_en[0]` = 0 leaves bits 1:0 unchanged.
- R11: While `acc_sel` is low, `rd_data` is 0 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_sel | input | 1 | Register selected for access |
| wr_en | input | 1 | Write strobe, qualified by `acc_sel` |
| byte_en | input | 2 | Byte lane enables; bit 1 is bits 15:8, bit 0 is bits 7:0 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, 0 when not selected |
| wake_evt | input | 1 | Wake-up event pulse |
| wake_n | output | 1 | Active-low wake request, registered |
| pwr_state | output | 2 | Current power state (00 = D0 to 11 = D3) |

## Verification
The bench builds the block with its default values: a scale threshold of 8 and a four-bit select field. With these values, all sixteen select codes, including both codes on either side of the scale boundary, can be swept exhaustively. The bench pairs every byte-enable combination with a set of data patterns and interleaves wake events between the writes. This covers every route into and out of `WK_PEND`, the event-against-clear collision, and the one-cycle lag on the wake output.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
    localparam int unsigned REG_W     = 16;
    localparam int unsigned BE_W      = REG_W / 8;
    localparam int unsigned SEL_W     = 4;
    localparam int unsigned PWR_W     = 2;
    localparam int unsigned SCALE_W   = 2;
    localparam int unsigned STAT_BIT  = 15;
    localparam int unsigned SCALE_LO  = 13;
    localparam int unsigned SEL_LO    = 9;
    localparam int unsigned EN_BIT    = 8;
    localparam int unsigned RSVD_LO   = 2;
    localparam int unsigned RSVD_W    = EN_BIT - RSVD_LO;
    localparam logic [SCALE_W-1:0] SCALE_LOW_SEL  = 2'b10;
    localparam logic [SCALE_W-1:0] SCALE_HIGH_SEL = 2'b00;

    typedef enum logic [PWR_W-1:0] {
        PWR_D0 = 2'b00,
        PWR_D1 = 2'b01,
        PWR_D2 = 2'b10,
        PWR_D3 = 2'b11
    } pm_pwr_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_PEND = 1'b1
    } pm_wake_e;
endpackage

// File: rtl/pm_wake_fsm.sv
module pm_wake_fsm
    import pm_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic wake_en,
    output logic status,
    output logic wake_n
);
    pm_wake_e state_q, state_d;
    logic     wake_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE: if (evt)         state_d = WK_PEND;
            WK_PEND: if (clr && !evt) state_d = WK_IDLE;
            default: state_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_n_q <= 1'b1;
        else        wake_n_q <= !((state_q == WK_PEND) && wake_en);
    end

    assign status = (state_q == WK_PEND);
    assign wake_n = wake_n_q;

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status);
    // R4
    evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr) |=> status);
    // R3
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !status);
    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
    // R5
    wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_en || !status) |=> wake_n);
    // R5
    wake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && wake_en) |=> !wake_n);
endmodule

// File: rtl/pm_ctrl_fields.sv
module pm_ctrl_fields
    import pm_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [BE_W-1:0]  be,
    input  logic [SEL_W-1:0] sel_d,
    input  logic             en_d,
    input  logic [PWR_W-1:0] pwr_d,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_q,
    output pm_pwr_e          pwr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_stb && be[1]) begin
            sel_q <= sel_d;
            en_q  <= en_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pwr_q <= PWR_D0;
        else if (wr_stb && be[0])   pwr_q <= pm_pwr_e'(pwr_d);
    end

    // R10
    hi_lane_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && be[1]) |=> ($stable(sel_q) && $stable(en_q)));
    // R10
    lo_lane_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && be[0]) |=> $stable(pwr_q));
endmodule

// File: rtl/pm_readback.sv
module pm_readback
    import pm_csr_pkg::*;
#(
    parameter int unsigned SCALE_SPLIT = 8
) (
    input  logic             acc_sel,
    input  logic             status,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    input  pm_pwr_e          pwr,
    output logic [REG_W-1:0] rd_data
);
    logic [SCALE_W-1:0] scale;
    logic [REG_W-1:0]   word;

    always_comb begin
        scale = (32'(sel) <= SCALE_SPLIT) ? SCALE_LOW_SEL : SCALE_HIGH_SEL;
        word  = {status, scale, sel, en, {RSVD_W{1'b0}}, pwr};
    end

    assign rd_data = acc_sel ? word : '0;
endmodule

// File: rtl/pm_csr_top.sv
module pm_csr_top
    import pm_csr_pkg::*;
#(
    parameter int unsigned SCALE_SPLIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_sel,
    input  logic              wr_en,
    input  logic [1:0]        byte_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic              wake_evt,
    output logic              wake_n,
    output logic [1:0]        pwr_state
);
    logic             wr_stb;
    logic             clr;
    logic             status;
    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    pm_pwr_e          pwr_q;
    logic             unused_wr_bits;

    assign wr_stb = acc_sel && wr_en;
    assign clr    = wr_stb && byte_en[1] && wr_data[STAT_BIT];
    assign unused_wr_bits = ^{wr_data[SCALE_LO+SCALE_W-1:SCALE_LO],
                              wr_data[EN_BIT-1:RSVD_LO]};

    pm_wake_fsm wake_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (wake_evt),
        .clr     (clr),
        .wake_en (en_q),
        .status  (status),
        .wake_n  (wake_n)
    );

    pm_ctrl_fields fields_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .be     (byte_en),
        .sel_d  (wr_data[SEL_LO+SEL_W-1:SEL_LO]),
        .en_d   (wr_data[EN_BIT]),
        .pwr_d  (wr_data[PWR_W-1:0]),
        .sel_q  (sel_q),
        .en_q   (en_q),
        .pwr_q  (pwr_q)
    );

    pm_readback #(.SCALE_SPLIT(SCALE_SPLIT)) rb_i (
        .acc_sel (acc_sel),
        .status  (status),
        .sel     (sel_q),
        .en      (en_q),
        .pwr     (pwr_q),
        .rd_data (rd_data)
    );

    assign pwr_state = pwr_q;

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[EN_BIT-1:RSVD_LO] == '0);
    // R7
    scale_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && (32'(rd_data[SEL_LO+SEL_W-1:SEL_LO]) > SCALE_SPLIT))
            |-> (rd_data[SCALE_LO+SCALE_W-1:SCALE_LO] == SCALE_HIGH_SEL));
    // R7
    scale_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && (32'(rd_data[SEL_LO+SEL_W-1:SEL_LO]) <= SCALE_SPLIT))
            |-> (rd_data[SCALE_LO+SCALE_W-1:SCALE_LO] == SCALE_LOW_SEL));
    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sel |-> (rd_data == '0));
    // R11
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sel |=> ($stable(pwr_state) && $stable(sel_q) && $stable(en_q)));
endmodule

// File: tb/pm_csr_tb.sv
module pm_csr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SPLIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [15:0] wr_data = '0;
    logic        wake_evt = 1'b0;
    logic [15:0] rd_data;
    logic        wake_n;
    logic [1:0]  pwr_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       m_stat = 1'b0;
    logic [3:0] m_sel  = '0;
    logic       m_en   = 1'b0;
    logic [1:0] m_pwr  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_csr_top #(.SCALE_SPLIT(SPLIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .wr_en(wr_en),
        .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data),
        .wake_evt(wake_evt), .wake_n(wake_n), .pwr_state(pwr_state)
    );

    function automatic logic [15:0] exp_word();
        logic [1:0] sc;
        sc = (int'(m_sel) <= SPLIT) ? 2'b10 : 2'b00;
        return {m_stat, sc, m_sel, m_en, 6'b0, m_pwr};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic evt);
        @(negedge clk);
        acc_sel = 1'b1; wr_en = 1'b1; byte_en = be; wr_data = d; wake_evt = evt;
        @(negedge clk);
        acc_sel = 1'b0; wr_en = 1'b0; byte_en = 2'b00; wake_evt = 1'b0;
        if (be[1]) begin
            m_sel = d[12:9]; m_en = d[8];
            if (d[15]) m_stat = 1'b0;
        end
        if (be[0]) m_pwr = d[1:0];
        if (evt) m_stat = 1'b1;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        m_stat = 1'b1;
    endtask

    task automatic rd_chk(input string req);
        acc_sel = 1'b1;
        #1;
        chk(rd_data == exp_word(), req, rd_data, exp_word());
        chk(pwr_state == m_pwr, "R8 pwr_state", {14'b0, pwr_state}, {14'b0, m_pwr});
        acc_sel = 1'b0;
    endtask

    task automatic wake_chk(input string req);
        @(negedge clk);
        chk(wake_n == !(m_stat && m_en), req, {15'b0, wake_n}, {15'b0, !(m_stat && m_en)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        acc_sel = 1'b1; #1;
        chk(rd_data == 16'h4000, "R1 reset read", rd_data, 16'h4000);
        chk(wake_n == 1'b1, "R1 reset wake_n", {15'b0, wake_n}, 16'h1);
        chk(pwr_state == 2'b00, "R1 reset pwr", {14'b0, pwr_state}, 16'h0);
        acc_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 after release");

        // R11: unselected write ignored and bus idle
        @(negedge clk);
        wr_en = 1'b1; byte_en = 2'b11; wr_data = 16'hFFFF;
        #1;
        chk(rd_data == 16'h0, "R11 idle bus", rd_data, 16'h0);
        @(negedge clk);
        wr_en = 1'b0; byte_en = 2'b00;
        rd_chk("R11 unselected write");

        // R2 event with enable off, wake stays high (R5)
        pulse_evt();
        rd_chk("R2 status set enable off");
        wake_chk("R5 disabled wake stays high");

        // R6/R7 exhaustive select sweep
        for (int s = 0; s < 16; s++) begin
            wr(2'b10, 16'(s) << 9, 1'b0);
            rd_chk("R7 R6 select sweep");
        end

        // R8 all power states
        for (int p = 0; p < 4; p++) begin
            wr(2'b01, 16'hFFFC | 16'(p), 1'b0);
            rd_chk("R8 R9 power state sweep");
        end

        // R3 write 0 to bit 15 keeps status
        wr(2'b10, 16'h0100, 1'b0);
        rd_chk("R3 write zero keeps status");
        // R5 enable on with status set: low one cycle later
        chk(wake_n == 1'b1, "R5 lag before assert", {15'b0, wake_n}, 16'h1);
        wake_chk("R5 wake asserted");

        // R4 collision
        wr(2'b10, 16'h8100, 1'b1);
        rd_chk("R4 event beats clear");

        // R3 clear, R5 lag then release
        wr(2'b10, 16'h8100, 1'b0);
        rd_chk("R3 clear");
        chk(wake_n == 1'b0, "R5 lag before release", {15'b0, wake_n}, 16'h0);
        wake_chk("R5 wake released");

        // R10 byte-lane sweep with data patterns and interleaved events
        for (int k = 0; k < 32; k++) begin
            logic [15:0] d;
            d = (16'(k) * 16'h2F1B) ^ 16'hA5C3;
            if (k % 3 == 0) pulse_evt();
            wr(2'(k % 4), d, 1'b0);
            rd_chk("R10 R9 byte lane sweep");
            wake_chk("R5 R2 sweep wake");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule